// File: doc/BRIEF.md
# Nested priority interrupt controller

This block decides when, and to which handler, a processor core is diverted by one of its maskable interrupt sources or by a software trap. Every maskable source has a two-bit software level held in a small register file. A pending source competes only if it is enabled and its level is strictly above the level the core is running at. Among the sources that compete, the highest software level wins, and a tie goes to the fixed hardware order, where the lower index wins. The block keeps the running level itself. On entry it loads the winner's level and pushes the old one onto a short internal stack. On return it pops the old level back. Software may also overwrite the running level directly, much as it would with its mask instructions.

The four software levels are stored in a non-monotonic two-bit code. Every comparison goes through a rank conversion, so no raw codes are ever compared. Requests are edge-sensitive. A rising edge is latched as pending, and the latch clears when that source is entered. Vector 0 also takes a group of active-low pins merged through a NAND, so any pin that is held low hides later edges on the others. While the core is halted, only sources flagged as able to wake it are considered. The next handler is then chosen among those, even if a stronger source that cannot wake the core is waiting.

The control state machine has three states. `ST_RUN` is normal execution. `ST_ENTRY` is the single cycle in which the take pulse is presented. `ST_HALT` is the halted state. The transitions are:
- RUN to ENTRY: an instruction-boundary strobe arrives while a trap or a qualified request is waiting.
- RUN to HALT: the halt strobe arrives.
- HALT to ENTRY: a wake-capable qualified request exists. No boundary strobe is needed for this.
- ENTRY to RUN: always, after one cycle.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset `take_o` is 0, `halted_o` is 0 and `lvl_o` is 2'b11, which is rank 3.
- R2: Level codes map to ranks as follows: 2'b10 is rank 0, 2'b01 is rank 1, 2'b00 is rank 2 and 2'b11 is rank 3. Every comparison between levels is made on rank.
- R3: A maskable request is serviced only if its enable bit is 1 and the rank of its software level is strictly greater than the rank of `lvl_o`. Otherwise it stays pending and is serviced once both conditions hold.
- R4: Among qualified requests, the highest rank wins. Among equal ranks, the lowest vector index wins.
- R5: On entry to a maskable vector, `lvl_o` becomes that vector's level code and the previous level is pushed. A pulse on `iret_i` pops and restores the previous level, so nested entries unwind in order.
- R6: A trap (pulse on `trap_i`) is latched and serviced at the next boundary regardless of `lvl_o`, ahead of any maskable request. It sets `vec_trap_o`=1, `vec_addr_o`=16'hFFFC and `lvl_o`=2'b11.
- R7: In the run state, `take_o` rises only in the cycle after a clock edge at which `boundary_i` was 1, and it stays high for exactly one cycle.
- R8: A rising edge on a request line is latched as pending, and the latch clears on entry to that vector. A line held high does not request again.
- R9: The line of vector 0 is `irq_raw_i[0]` OR the NAND of all bits of `ext_pins_n_i`. While any pin is held low, a falling edge on another pin produces no request.
- R10: In the halt state, only vectors whose bit is set in `WAKE_MASK` are serviced, and they are serviced without a boundary strobe. The default `WAKE_MASK` has bits 1 and 2 set.
- R11: The handler address of maskable vector i is 16'hFFFA minus 2*i, and `vec_idx_o` is i.
- R12: Every software level register resets to 2'b11 and is written by `prio_we_i`, `prio_idx_i` and `prio_wdata_i` at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_raw_i | input | NVEC | Rising-edge request lines, one per vector |
| ext_pins_n_i | input | SHARE_W | Active-low pins merged into vector 0 |
| irq_en_i | input | NVEC | Per-vector enable |
| prio_we_i | input | 1 | Software level write strobe |
| prio_idx_i | input | IDXW | Vector whose level is written |
| prio_wdata_i | input | 2 | Level code to write |
| lvl_we_i | input | 1 | Direct write of the running level |
| lvl_wdata_i | input | 2 | Running level code to write |
| boundary_i | input | 1 | Instruction-boundary strobe |
| trap_i | input | 1 | Software trap pulse |
| halt_i | input | 1 | Enter the halt state |
| iret_i | input | 1 | Return from handler, which restores the level |
| take_o | output | 1 | One-cycle take-interrupt pulse |
| vec_trap_o | output | 1 | The taken vector is the trap |
| vec_idx_o | output | IDXW | Index of the taken maskable vector |
| vec_addr_o | output | 16 | Handler address |
| lvl_o | output | 2 | Running level code |
| halted_o | output | 1 | The block is in the halt state |

## Verification
A request raised after a falling edge is latched at the next rising edge. It can only be taken at a later edge, so the bench always lets one edge pass before it pulses `boundary_i`. The take outputs and the new level are registered at the edge that sees the boundary strobe. The bench samples them at the following falling edge and checks that `take_o` is low again one edge later. In the halt state, a wake request appears as a take two edges after the line rises. Level writes and returns show up one edge after their strobe. The main sweep covers every vector against every pair of request level and running level.

// File: rtl/nic_pkg.sv
package nic_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTRY = 2'd1,
        ST_HALT  = 2'd2
    } nic_state_e;

    localparam logic [1:0] LVL_R0 = 2'b10;
    localparam logic [1:0] LVL_R1 = 2'b01;
    localparam logic [1:0] LVL_R2 = 2'b00;
    localparam logic [1:0] LVL_R3 = 2'b11;

    // Converts the stored two-bit level code to its rank (R2)
    function automatic logic [1:0] lvl_rank(input logic [1:0] code);
        logic [1:0] r;
        case (code)
            LVL_R0:  r = 2'd0;
            LVL_R1:  r = 2'd1;
            LVL_R2:  r = 2'd2;
            default: r = 2'd3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nic_req_latch.sv
module nic_req_latch #(
    parameter int NVEC    = 10,
    parameter int SHARE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NVEC-1:0]    irq_raw_i,
    input  logic [SHARE_W-1:0] pins_n_i,
    input  logic [NVEC-1:0]    clr_i,
    output logic [NVEC-1:0]    pend_o
);

    logic [NVEC-1:0] line;
    logic [NVEC-1:0] line_q;
    logic [NVEC-1:0] edge_det;
    logic [NVEC-1:0] pend_q;

    genvar g;
    generate
        for (g = 0; g < NVEC; g++) begin : g_line
            if (g == 0) begin : g_shared
                // R9: any pin held low keeps the merged line high
                assign line[g] = irq_raw_i[g] | ~(&pins_n_i);
            end else begin : g_plain
                assign line[g] = irq_raw_i[g];
            end
        end
    endgenerate

    assign edge_det = line & ~line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            pend_q <= '0;
        end else begin
            line_q <= line;
            pend_q <= (pend_q & ~clr_i) | edge_det;
        end
    end

    assign pend_o = pend_q;

    // R8: a serviced vector leaves the pending set unless a fresh edge came
    p_clear_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((pend_q & $past(clr_i & ~edge_det)) == '0));

endmodule

// File: rtl/nic_prio_regs.sv
module nic_prio_regs #(
    parameter int NVEC = 10,
    parameter int IDXW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDXW-1:0]   idx_i,
    input  logic [1:0]        wdata_i,
    output logic [2*NVEC-1:0] prio_o
);

    genvar g;
    generate
        for (g = 0; g < NVEC; g++) begin : g_reg
            logic [1:0] code_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    code_q <= nic_pkg::LVL_R3;
                end else if (we_i && (idx_i == IDXW'(g))) begin
                    code_q <= wdata_i;
                end
            end
            assign prio_o[2*g +: 2] = code_q;

            p_prio_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
                (we_i && (idx_i == IDXW'(g))) |=> (prio_o[2*g +: 2] == $past(wdata_i)));
        end
    endgenerate

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
    parameter int              NVEC      = 10,
    parameter int              IDXW      = 4,
    parameter logic [NVEC-1:0] WAKE_MASK = '0
) (
    input  logic [NVEC-1:0]   pend_i,
    input  logic [NVEC-1:0]   en_i,
    input  logic [2*NVEC-1:0] prio_i,
    input  logic [1:0]        cur_lvl_i,
    input  logic              halted_i,
    output logic              valid_o,
    output logic [IDXW-1:0]   idx_o,
    output logic [1:0]        lvl_o
);
    import nic_pkg::*;

    logic [NVEC-1:0] cand;

    // Stage one: qualify each request against enable, wake ability and level
    always_comb begin
        for (int v = 0; v < NVEC; v++) begin
            cand[v] = pend_i[v] & en_i[v] & (~halted_i | WAKE_MASK[v]) &
                      (lvl_rank(prio_i[2*v +: 2]) > lvl_rank(cur_lvl_i));
        end
    end

    // Stage two: highest rank, ties to the lowest index
    always_comb begin
        logic [1:0] best_r;
        logic       found;
        best_r  = 2'd0;
        found   = 1'b0;
        idx_o   = '0;
        lvl_o   = LVL_R3;
        for (int v = NVEC - 1; v >= 0; v--) begin
            if (cand[v] && (!found || (lvl_rank(prio_i[2*v +: 2]) >= best_r))) begin
                found  = 1'b1;
                best_r = lvl_rank(prio_i[2*v +: 2]);
                idx_o  = IDXW'(v);
                lvl_o  = prio_i[2*v +: 2];
            end
        end
        valid_o = found;
    end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
    parameter int              NVEC      = 10,
    parameter int              SHARE_W   = 4,
    parameter int              DEPTH     = 8,
    parameter logic [NVEC-1:0] WAKE_MASK = 10'b00_0000_0110,
    localparam int             IDXW      = $clog2(NVEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NVEC-1:0]    irq_raw_i,
    input  logic [SHARE_W-1:0] ext_pins_n_i,
    input  logic [NVEC-1:0]    irq_en_i,
    input  logic               prio_we_i,
    input  logic [IDXW-1:0]    prio_idx_i,
    input  logic [1:0]         prio_wdata_i,
    input  logic               lvl_we_i,
    input  logic [1:0]         lvl_wdata_i,
    input  logic               boundary_i,
    input  logic               trap_i,
    input  logic               halt_i,
    input  logic               iret_i,
    output logic               take_o,
    output logic               vec_trap_o,
    output logic [IDXW-1:0]    vec_idx_o,
    output logic [15:0]        vec_addr_o,
    output logic [1:0]         lvl_o,
    output logic               halted_o
);
    import nic_pkg::*;

    localparam int             SPW     = $clog2(DEPTH) + 1;
    localparam logic [SPW-1:0] SP_FULL = SPW'(DEPTH);

    nic_state_e         state_q, state_d;
    logic [NVEC-1:0]    pend;
    logic [NVEC-1:0]    clr;
    logic [2*NVEC-1:0]  prio;
    logic               win_valid;
    logic [IDXW-1:0]    win_idx;
    logic [1:0]         win_lvl;
    logic               trap_pend_q;
    logic               take_now;
    logic               take_trap;
    logic [1:0]         cur_lvl_q;
    logic [1:0]         stk_q [DEPTH];
    logic [SPW-1:0]     sp_q;
    logic [SPW-1:0]     sp_m1;
    logic [1:0]         stk_top;

    nic_req_latch #(.NVEC(NVEC), .SHARE_W(SHARE_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_raw_i (irq_raw_i),
        .pins_n_i  (ext_pins_n_i),
        .clr_i     (clr),
        .pend_o    (pend)
    );

    nic_prio_regs #(.NVEC(NVEC), .IDXW(IDXW)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (prio_we_i),
        .idx_i   (prio_idx_i),
        .wdata_i (prio_wdata_i),
        .prio_o  (prio)
    );

    nic_arbiter #(.NVEC(NVEC), .IDXW(IDXW), .WAKE_MASK(WAKE_MASK)) u_arb (
        .pend_i    (pend),
        .en_i      (irq_en_i),
        .prio_i    (prio),
        .cur_lvl_i (cur_lvl_q),
        .halted_i  (state_q == ST_HALT),
        .valid_o   (win_valid),
        .idx_o     (win_idx),
        .lvl_o     (win_lvl)
    );

    // Take decision and next state
    always_comb begin
        state_d   = state_q;
        take_now  = 1'b0;
        take_trap = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (boundary_i && (trap_pend_q || win_valid)) begin
                    take_now  = 1'b1;
                    take_trap = trap_pend_q;
                    state_d   = ST_ENTRY;
                end else if (halt_i) begin
                    state_d = ST_HALT;
                end
            end
            ST_ENTRY: begin
                state_d = ST_RUN;
            end
            ST_HALT: begin
                if (win_valid) begin
                    take_now = 1'b1;
                    state_d  = ST_ENTRY;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign clr = (take_now && !take_trap) ? (NVEC'(1) << win_idx) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs, running level, trap latch and level stack
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_o      <= 1'b0;
            vec_trap_o  <= 1'b0;
            vec_idx_o   <= '0;
            vec_addr_o  <= 16'hFFFE;
            cur_lvl_q   <= LVL_R3;
            trap_pend_q <= 1'b0;
            sp_q        <= '0;
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= LVL_R3;
        end else begin
            take_o <= take_now;
            if (take_trap) begin
                trap_pend_q <= 1'b0;
            end else if (trap_i) begin
                trap_pend_q <= 1'b1;
            end
            if (take_now) begin
                vec_trap_o <= take_trap;
                vec_idx_o  <= take_trap ? '0 : win_idx;
                vec_addr_o <= take_trap ? 16'hFFFC : (16'hFFFA - (16'(win_idx) << 1));
                cur_lvl_q  <= take_trap ? LVL_R3 : win_lvl;
                if (sp_q != SP_FULL) begin
                    stk_q[sp_q[SPW-2:0]] <= cur_lvl_q;
                    sp_q                 <= sp_q + 1'b1;
                end
            end else if (iret_i && (sp_q != '0)) begin
                cur_lvl_q <= stk_top;
                sp_q      <= sp_m1;
            end else if (lvl_we_i) begin
                cur_lvl_q <= lvl_wdata_i;
            end
        end
    end

    assign sp_m1    = sp_q - 1'b1;
    assign stk_top  = (sp_q != '0) ? stk_q[sp_m1[SPW-2:0]] : LVL_R3;
    assign lvl_o    = cur_lvl_q;
    assign halted_o = (state_q == ST_HALT);

    p_take_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    p_take_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ($past(state_q) != ST_HALT)) |-> $past(boundary_i));

    p_trap_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_trap_o) |-> (lvl_o == LVL_R3));

    p_nest_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !vec_trap_o && (sp_q != '0) && ($past(sp_q) != SP_FULL))
        |-> (lvl_rank(lvl_o) > lvl_rank(stk_top)));

    p_wake_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ($past(state_q) == ST_HALT)) |-> WAKE_MASK[vec_idx_o]);

endmodule

// File: tb/sim_irq_nest_ctrl.sv
module sim_irq_nest_ctrl;

    localparam int CLK_P = 10;
    localparam int NV    = 10;
    localparam int IW    = 4;
    localparam int SW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NV-1:0] irq_raw = '0;
    logic [SW-1:0] pins_n = '1;
    logic [NV-1:0] irq_en = '1;
    logic          prio_we = 1'b0;
    logic [IW-1:0] prio_idx = '0;
    logic [1:0]    prio_wdata = 2'b11;
    logic          lvl_we = 1'b0;
    logic [1:0]    lvl_wdata = 2'b11;
    logic          boundary = 1'b0;
    logic          trap = 1'b0;
    logic          halt = 1'b0;
    logic          iret = 1'b0;
    logic          take;
    logic          vtrap;
    logic [IW-1:0] vidx;
    logic [15:0]   vaddr;
    logic [1:0]    lvl;
    logic          halted;

    int checks = 0;
    int errors = 0;

    always #(CLK_P / 2) clk = ~clk;

    irq_nest_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_raw_i    (irq_raw),
        .ext_pins_n_i (pins_n),
        .irq_en_i     (irq_en),
        .prio_we_i    (prio_we),
        .prio_idx_i   (prio_idx),
        .prio_wdata_i (prio_wdata),
        .lvl_we_i     (lvl_we),
        .lvl_wdata_i  (lvl_wdata),
        .boundary_i   (boundary),
        .trap_i       (trap),
        .halt_i       (halt),
        .iret_i       (iret),
        .take_o       (take),
        .vec_trap_o   (vtrap),
        .vec_idx_o    (vidx),
        .vec_addr_o   (vaddr),
        .lvl_o        (lvl),
        .halted_o     (halted)
    );

    // Rank to code, written from the R2 table
    function automatic logic [1:0] enc(input int r);
        case (r)
            0:       return 2'b10;
            1:       return 2'b01;
            2:       return 2'b00;
            default: return 2'b11;
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_prio(input int v, input logic [1:0] code);
        prio_we = 1'b1; prio_idx = IW'(v); prio_wdata = code;
        step();
        prio_we = 1'b0;
    endtask

    task automatic set_lvl(input logic [1:0] code);
        lvl_we = 1'b1; lvl_wdata = code;
        step();
        lvl_we = 1'b0;
    endtask

    task automatic fire();
        boundary = 1'b1;
        step();
        boundary = 1'b0;
    endtask

    task automatic ret();
        iret = 1'b1;
        step();
        iret = 1'b0;
    endtask

    task automatic expect_vec(input string req, input int v, input logic [1:0] code);
        chk({req, " take"}, 32'(take), 32'd1);
        chk({req, " idx"}, 32'(vidx), 32'(v));
        chk({req, " addr R11"}, 32'(vaddr), 32'(16'hFFFA - 16'(2 * v)));
        chk({req, " level"}, 32'(lvl), 32'(code));
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 take", 32'(take), 32'd0);
        chk("R1 halted", 32'(halted), 32'd0);
        chk("R1 level", 32'(lvl), 32'(2'b11));

        // R12 reset level of every vector is 11
        set_lvl(2'b10);
        irq_raw[1] = 1'b1; step();
        fire();
        expect_vec("R12 reset prio", 1, 2'b11);
        ret();
        chk("R5 restore after R12", 32'(lvl), 32'(2'b10));
        irq_raw[1] = 1'b0; step();

        // R2/R3/R5/R11 sweep: every vector, every request rank, every running rank
        for (int v = 0; v < NV; v++) begin
            for (int p = 0; p < 4; p++) begin
                for (int c = 0; c < 4; c++) begin
                    set_prio(v, enc(p));
                    set_lvl(enc(c));
                    irq_raw[v] = 1'b1; step();
                    fire();
                    if (p > c) begin
                        expect_vec("R3 sweep", v, enc(p));
                        ret();
                        chk("R5 sweep restore", 32'(lvl), 32'(enc(c)));
                    end else begin
                        chk("R3 sweep held", 32'(take), 32'd0);
                        set_prio(v, 2'b11);
                        set_lvl(2'b10);
                        fire();
                        expect_vec("R3 pending kept", v, 2'b11);
                        ret();
                    end
                    irq_raw[v] = 1'b0; step();
                end
            end
        end

        // R3 enable gating
        set_prio(4, 2'b11); set_lvl(2'b10);
        irq_en[4] = 1'b0;
        irq_raw[4] = 1'b1; step();
        fire();
        chk("R3 disabled", 32'(take), 32'd0);
        irq_en[4] = 1'b1;
        fire();
        expect_vec("R3 enabled later", 4, 2'b11);
        ret();
        irq_raw[4] = 1'b0; step();

        // R4 rank wins, then lower rank follows after return
        set_prio(3, 2'b01); set_prio(7, 2'b00); set_lvl(2'b10);
        irq_raw[3] = 1'b1; irq_raw[7] = 1'b1; step();
        fire();
        expect_vec("R4 rank", 7, 2'b00);
        fire();
        chk("R4 lower rank blocked", 32'(take), 32'd0);
        ret();
        chk("R5 back to rank0", 32'(lvl), 32'(2'b10));
        fire();
        expect_vec("R4 second", 3, 2'b01);
        ret();
        irq_raw[3] = 1'b0; irq_raw[7] = 1'b0; step();

        // R4 tie goes to lower index
        set_prio(2, 2'b00); set_prio(5, 2'b00);
        irq_raw[2] = 1'b1; irq_raw[5] = 1'b1; step();
        fire();
        expect_vec("R4 tie", 2, 2'b00);
        ret();
        fire();
        expect_vec("R4 tie second", 5, 2'b00);
        ret();
        irq_raw[2] = 1'b0; irq_raw[5] = 1'b0; step();

        // R5 nested preemption unwinds in order
        set_prio(6, 2'b01); set_prio(8, 2'b11);
        irq_raw[6] = 1'b1; step();
        fire();
        expect_vec("R5 outer", 6, 2'b01);
        irq_raw[8] = 1'b1; step();
        fire();
        expect_vec("R5 inner", 8, 2'b11);
        ret();
        chk("R5 pop inner", 32'(lvl), 32'(2'b01));
        ret();
        chk("R5 pop outer", 32'(lvl), 32'(2'b10));
        irq_raw[6] = 1'b0; irq_raw[8] = 1'b0; step();

        // R6 trap ignores level 11
        set_prio(1, 2'b11); set_lvl(2'b11);
        irq_raw[1] = 1'b1; step();
        trap = 1'b1; step(); trap = 1'b0;
        fire();
        chk("R6 take", 32'(take), 32'd1);
        chk("R6 trap flag", 32'(vtrap), 32'd1);
        chk("R6 addr", 32'(vaddr), 32'h0000FFFC);
        chk("R6 level", 32'(lvl), 32'(2'b11));
        ret();
        chk("R6 restore", 32'(lvl), 32'(2'b11));
        set_lvl(2'b10);
        fire();
        expect_vec("R6 vec after trap", 1, 2'b11);
        chk("R6 flag low", 32'(vtrap), 32'd0);
        ret();
        irq_raw[1] = 1'b0; step();

        // R6 trap beats a pending maskable request
        set_prio(9, 2'b11);
        irq_raw[9] = 1'b1; step();
        trap = 1'b1; step(); trap = 1'b0;
        fire();
        chk("R6 trap first", 32'(vtrap), 32'd1);
        ret();
        fire();
        expect_vec("R6 maskable next", 9, 2'b11);
        ret();
        irq_raw[9] = 1'b0; step();

        // R7 no take without boundary; one-cycle pulse
        irq_raw[5] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R7 no boundary", 32'(take), 32'd0);
        end
        fire();
        chk("R7 take after boundary", 32'(take), 32'd1);
        step();
        chk("R7 single pulse", 32'(take), 32'd0);
        ret();

        // R8 held line does not request again; new edge does
        fire();
        chk("R8 held line", 32'(take), 32'd0);
        irq_raw[5] = 1'b0; step();
        irq_raw[5] = 1'b1; step();
        fire();
        expect_vec("R8 new edge", 5, 2'b00);
        ret();
        irq_raw[5] = 1'b0; step();

        // R9 shared pins merged by NAND into vector 0
        set_prio(0, 2'b11);
        pins_n[0] = 1'b0; step();
        fire();
        expect_vec("R9 pin edge", 0, 2'b11);
        ret();
        pins_n[1] = 1'b0; step();
        fire();
        chk("R9 masked pin", 32'(take), 32'd0);
        pins_n = '1; step();
        pins_n[2] = 1'b0; step();
        fire();
        expect_vec("R9 pin after release", 0, 2'b11);
        ret();
        pins_n = '1; step();

        // R10 halt wakes only on wake-capable vectors, no boundary needed
        set_prio(2, 2'b11);
        halt = 1'b1; step(); halt = 1'b0;
        chk("R10 halted", 32'(halted), 32'd1);
        irq_raw[0] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R10 non-wake ignored", 32'(take), 32'd0);
        end
        irq_raw[2] = 1'b1; step();
        step();
        expect_vec("R10 wake", 2, 2'b11);
        chk("R10 left halt", 32'(halted), 32'd0);
        ret();
        fire();
        expect_vec("R10 deferred", 0, 2'b11);
        ret();
        irq_raw = '0; step();

        summary();
    end

endmodule